// File: doc/BRIEF.md
# Rotate-Mask-ALU-Merge Datapath

This block is an 8-bit execution datapath that completes one 16-bit instruction per clock, with no overlap between instructions. The first operand is taken from a general register, from the one-bit overflow register, or from an I/O port in a left or right bank. That operand is rotated right, cut down to a field of 1 to 8 bits, and then combined with the auxiliary register by a four-function ALU. A register-field code either names a storage location or selects an I/O operation. When the destination code selects I/O, the result is rotated back into place and merged into the I/O buffer. Only the selected field changes. The new buffer value is then sent to the chosen port bank.

Data bits are numbered with bit 0 as the most significant bit and bit 7 as the least significant, so every data port is declared `[0:7]`. Instruction fetch, the program counter and the port address latches sit outside the block. The surrounding logic presents each instruction together with a valid flag and supplies the byte read from the selected port.

Top module: `rmam_datapath`

## Requirements
- R1: The instruction word is laid out as: bits [15:14] ALU function, [13:10] source code, [9:6] destination code, [5:3] rotate/shift amount, [2:0] field length minus one. Every instruction completes in one clock.
- R2: The ALU functions are 0 = move, 1 = add, 2 = AND, 3 = exclusive-OR. The second ALU operand is always the auxiliary register (code 0). A register destination receives the full 8-bit ALU result.
- R3: Codes 0-6 and 9 are data registers. Code 8 is the overflow bit: as a source it reads as 0000000 followed by the bit, and as a destination it takes result bit 7. Codes 7 and 10-15 select I/O, and the bank is code bit 3 (0 = left, 1 = right).
- R4: The source value is rotated right by the amount field, toward bit 7. It is then ANDed with a field of (length+1) ones that ends at bit 7.
- R5: An add writes its carry-out to the overflow bit, and this takes precedence over a code-8 destination. Move, AND and XOR leave the overflow bit alone unless the destination is code 8.
- R6: For an I/O source, port_rd_o is high in the same cycle and port_rd_bank_o gives the bank. The operand is port_rd_data_i, and the I/O buffer loads that byte.
- R7: For an I/O destination, the field mask and the ALU result are both rotated left by the amount field. Buffer bits inside the rotated mask take the rotated result, and bits outside it keep their value. The base is the freshly read byte when the source is also I/O.
- R8: In the cycle after an I/O-destination instruction, port_wr_o is high for one cycle, port_wr_bank_o gives the destination bank, and port_wr_data_o holds the new buffer value. port_wr_data_o always shows the I/O buffer.
- R9: With instr_valid_i low, no register, overflow bit or buffer changes, and port_rd_o and port_wr_o stay low.
- R10: After reset, all registers, the overflow bit and the buffer are zero, and port_wr_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Execute instr_i on this edge |
| port_rd_data_i | input | 8 | Byte from the selected port, bit 0 MSB |
| port_rd_o | output | 1 | I/O source read this cycle |
| port_rd_bank_o | output | 1 | Read bank, 0 left, 1 right |
| port_wr_o | output | 1 | I/O buffer updated, write to port |
| port_wr_bank_o | output | 1 | Write bank, 0 left, 1 right |
| port_wr_data_o | output | 8 | I/O buffer contents, bit 0 MSB |

## Verification
The read strobe and read bank are combinational, so they are sampled 1 ns after the instruction is driven, before the next clock edge. The buffer, registers and overflow bit update on the edge that executes the instruction. The write strobe, write bank and buffer value are therefore sampled at the following falling edge, one edge after the instruction. Register and overflow contents are read back through a full-width move to an I/O destination, and that move is checked one edge later in the same way. Idle cycles are checked at that same point to confirm that nothing moved.

// File: rtl/rmam_pkg.sv
package rmam_pkg;
  typedef enum logic [1:0] {OP_MOV = 2'd0, OP_ADD = 2'd1, OP_AND = 2'd2, OP_XOR = 2'd3} alu_op_e;

  localparam int unsigned CODE_W = 4;
  localparam int unsigned SLOT_W = 3;
  localparam int unsigned NSLOT  = 1 << SLOT_W;
  localparam logic [CODE_W-1:0] CODE_OVF = 4'd8;

  function automatic logic is_io(input logic [CODE_W-1:0] c);
    return (c == 4'd7) || (c >= 4'd10);
  endfunction

  // code 9 lives in slot 7
  function automatic logic [SLOT_W-1:0] slot_of(input logic [CODE_W-1:0] c);
    return (c == 4'd9) ? 3'd7 : c[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/rmam_rotmask.sv
module rmam_rotmask #(
  parameter int unsigned DW = 8,
  localparam int unsigned RW = $clog2(DW)
) (
  input  logic [0:DW-1] data_i,
  input  logic [RW-1:0] rot_i,
  input  logic [RW-1:0] len_i,
  output logic [0:DW-1] field_o,
  output logic [0:DW-1] mask_o
);
  logic [0:DW-1] ones;
  logic [0:DW-1] rotated;

  assign ones    = '1;
  assign rotated = (data_i >> rot_i) | (data_i << (DW - int'(rot_i)));
  assign mask_o  = ~(ones << (int'(len_i) + 1));
  assign field_o = rotated & mask_o;
endmodule

// File: rtl/rmam_alu.sv
module rmam_alu
  import rmam_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [0:DW-1] a_i,
  input  logic [0:DW-1] aux_i,
  output logic [0:DW-1] res_o,
  output logic          carry_o
);
  logic [DW:0] sum;

  assign sum = {1'b0, a_i} + {1'b0, aux_i};

  always_comb begin
    carry_o = 1'b0;
    unique case (op_i)
      OP_MOV: res_o = a_i;
      OP_ADD: begin
        res_o   = sum[DW-1:0];
        carry_o = sum[DW];
      end
      OP_AND: res_o = a_i & aux_i;
      OP_XOR: res_o = a_i ^ aux_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/rmam_merge.sv
module rmam_merge #(
  parameter int unsigned DW = 8,
  localparam int unsigned RW = $clog2(DW)
) (
  input  logic [0:DW-1] base_i,
  input  logic [0:DW-1] res_i,
  input  logic [0:DW-1] mask_i,
  input  logic [RW-1:0] rot_i,
  output logic [0:DW-1] merged_o
);
  logic [0:DW-1] res_sh;
  logic [0:DW-1] mask_sh;

  assign res_sh   = (res_i  << rot_i) | (res_i  >> (DW - int'(rot_i)));
  assign mask_sh  = (mask_i << rot_i) | (mask_i >> (DW - int'(rot_i)));
  assign merged_o = (base_i & ~mask_sh) | (res_sh & mask_sh);
endmodule

// File: rtl/rmam_regfile.sv
module rmam_regfile
  import rmam_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wslot_i,
  input  logic [0:DW-1]     wdata_i,
  input  logic [SLOT_W-1:0] rslot_i,
  output logic [0:DW-1]     rdata_o,
  output logic [0:DW-1]     aux_o
);
  logic [0:DW-1] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[g] <= '0;
      else if (we_i && (wslot_i == SLOT_W'(g)))       slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[rslot_i];
  assign aux_o   = slot_q[0];
endmodule

// File: rtl/rmam_datapath.sv
module rmam_datapath
  import rmam_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned RW = $clog2(DW),
  localparam int unsigned IW = 2 + 2 * CODE_W + 2 * RW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] instr_i,
  input  logic          instr_valid_i,
  input  logic [0:DW-1] port_rd_data_i,
  output logic          port_rd_o,
  output logic          port_rd_bank_o,
  output logic          port_wr_o,
  output logic          port_wr_bank_o,
  output logic [0:DW-1] port_wr_data_o
);
  localparam int unsigned LEN_LSB = 0;
  localparam int unsigned ROT_LSB = RW;
  localparam int unsigned DST_LSB = 2 * RW;
  localparam int unsigned SRC_LSB = DST_LSB + CODE_W;
  localparam int unsigned OP_LSB  = SRC_LSB + CODE_W;

  alu_op_e           op;
  logic [CODE_W-1:0] src, dst;
  logic [RW-1:0]     rot, len;
  logic              src_io, dst_io, src_ovf, dst_ovf;

  assign op      = alu_op_e'(instr_i[OP_LSB +: 2]);
  assign src     = instr_i[SRC_LSB +: CODE_W];
  assign dst     = instr_i[DST_LSB +: CODE_W];
  assign rot     = instr_i[ROT_LSB +: RW];
  assign len     = instr_i[LEN_LSB +: RW];
  assign src_io  = is_io(src);
  assign dst_io  = is_io(dst);
  assign src_ovf = (src == CODE_OVF);
  assign dst_ovf = (dst == CODE_OVF);

  logic          ovf_q, wr_q, wr_bank_q;
  logic [0:DW-1] ivb_q;
  logic [0:DW-1] rf_rd, aux, src_val, field, mask, res, merged, base;
  logic          carry;

  rmam_regfile #(.DW(DW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (instr_valid_i && !dst_io && !dst_ovf),
    .wslot_i (slot_of(dst)),
    .wdata_i (res),
    .rslot_i (slot_of(src)),
    .rdata_o (rf_rd),
    .aux_o   (aux)
  );

  always_comb begin
    if (src_io)       src_val = port_rd_data_i;
    else if (src_ovf) src_val = {{(DW-1){1'b0}}, ovf_q};
    else              src_val = rf_rd;
  end

  rmam_rotmask #(.DW(DW)) u_rm (
    .data_i  (src_val),
    .rot_i   (rot),
    .len_i   (len),
    .field_o (field),
    .mask_o  (mask)
  );

  rmam_alu #(.DW(DW)) u_alu (
    .op_i    (op),
    .a_i     (field),
    .aux_i   (aux),
    .res_o   (res),
    .carry_o (carry)
  );

  assign base = src_io ? port_rd_data_i : ivb_q;

  rmam_merge #(.DW(DW)) u_mg (
    .base_i   (base),
    .res_i    (res),
    .mask_i   (mask),
    .rot_i    (rot),
    .merged_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivb_q     <= '0;
      ovf_q     <= 1'b0;
      wr_q      <= 1'b0;
      wr_bank_q <= 1'b0;
    end else begin
      wr_q <= instr_valid_i && dst_io;
      if (instr_valid_i) begin
        if (dst_io) begin
          ivb_q     <= merged;
          wr_bank_q <= dst[3];
        end else if (src_io) begin
          ivb_q <= port_rd_data_i;
        end
        // add carry wins over a code-8 destination
        if (op == OP_ADD) ovf_q <= carry;
        else if (dst_ovf) ovf_q <= res[DW-1];
      end
    end
  end

  assign port_rd_o      = instr_valid_i && src_io;
  assign port_rd_bank_o = src[3];
  assign port_wr_o      = wr_q;
  assign port_wr_bank_o = wr_bank_q;
  assign port_wr_data_o = ivb_q;
endmodule

// File: rtl/rmam_checker.sv
module rmam_checker
  import rmam_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned RW = $clog2(DW),
  localparam int unsigned IW = 2 + 2 * CODE_W + 2 * RW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] instr_i,
  input logic          instr_valid_i,
  input logic          port_rd_o,
  input logic          port_rd_bank_o,
  input logic          port_wr_o,
  input logic          port_wr_bank_o,
  input logic [0:DW-1] port_wr_data_o
);
  logic [CODE_W-1:0] c_src, c_dst;
  logic [RW-1:0]     c_rot, c_len;
  logic [0:DW-1]     c_ones, c_mask, c_fmask;
  logic              c_wr_io, c_rd_io;

  assign c_src   = instr_i[2*RW+CODE_W +: CODE_W];
  assign c_dst   = instr_i[2*RW +: CODE_W];
  assign c_rot   = instr_i[RW +: RW];
  assign c_len   = instr_i[0 +: RW];
  assign c_ones  = '1;
  assign c_mask  = ~(c_ones << (int'(c_len) + 1));
  assign c_fmask = (c_mask << c_rot) | (c_mask >> (DW - int'(c_rot)));
  assign c_wr_io = instr_valid_i && is_io(c_dst);
  assign c_rd_io = instr_valid_i && is_io(c_src);

  AST_WR_AFTER_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr_io |=> port_wr_o); // R8
  AST_NO_SPURIOUS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_wr_io |=> !port_wr_o); // R9
  AST_WR_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr_io |=> (port_wr_bank_o == $past(c_dst[3]))); // R3
  AST_IVB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> $stable(port_wr_data_o)); // R9
  AST_OUTSIDE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr_io && !c_rd_io) |=> (((port_wr_data_o ^ $past(port_wr_data_o)) & ~$past(c_fmask)) == '0)); // R7
  AST_RD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rd_o |-> (instr_valid_i && is_io(c_src) && (port_rd_bank_o == c_src[3]))); // R6
endmodule

bind rmam_datapath rmam_checker #(.DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .instr_i        (instr_i),
  .instr_valid_i  (instr_valid_i),
  .port_rd_o      (port_rd_o),
  .port_rd_bank_o (port_rd_bank_o),
  .port_wr_o      (port_wr_o),
  .port_wr_bank_o (port_wr_bank_o),
  .port_wr_data_o (port_wr_data_o)
);

// File: tb/rmam_datapath_test.sv
`timescale 1ns/1ps
module rmam_datapath_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic        instr_valid_i = 1'b0;
  logic [0:7]  port_rd_data_i;
  logic        port_rd_o, port_rd_bank_o, port_wr_o, port_wr_bank_o;
  logic [0:7]  port_wr_data_o;

  logic [7:0] left_d = '0, right_d = '0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_reg [8];
  logic       m_ovf;
  logic [7:0] m_ivb;

  always #4 clk_i = ~clk_i;
  assign port_rd_data_i = port_rd_bank_o ? right_d : left_d;

  rmam_datapath uut (
    .clk_i, .rst_ni, .instr_i, .instr_valid_i, .port_rd_data_i,
    .port_rd_o, .port_rd_bank_o, .port_wr_o, .port_wr_bank_o, .port_wr_data_o
  );

  function automatic logic [7:0] rotr(input logic [7:0] v, input int r);
    return (v >> r) | (v << (8 - r));
  endfunction
  function automatic logic [7:0] rotl(input logic [7:0] v, input int r);
    return (v << r) | (v >> (8 - r));
  endfunction
  function automatic logic [7:0] fmask(input int l);
    return 8'((9'd1 << (l + 1)) - 9'd1);
  endfunction
  function automatic bit io_code(input logic [3:0] c);
    return (c == 4'd7) || (c >= 4'd10);
  endfunction
  function automatic int slot(input logic [3:0] c);
    return (c == 4'd9) ? 7 : int'(c[2:0]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // executes one instruction, checks R6 read side and R8 write side
  task automatic exec(input logic [1:0] op, input logic [3:0] src, input logic [3:0] dst,
                      input int rot, input int len, input string req);
    logic [7:0] pd, v, fld, aux, res, mk, base;
    logic       cy;
    bit         exp_wr;
    instr_i = {op, src, dst, 3'(rot), 3'(len)};
    instr_valid_i = 1'b1;
    #1;
    if (io_code(src)) begin
      check("R6 rd strobe", port_rd_o, 1);
      check("R6 rd bank", port_rd_bank_o, src[3]);
    end else check("R6 no rd", port_rd_o, 0);
    pd  = src[3] ? right_d : left_d;
    if (io_code(src)) v = pd;
    else if (src == 4'd8) v = {7'd0, m_ovf};
    else v = m_reg[slot(src)];
    mk  = fmask(len);
    fld = rotr(v, rot) & mk;
    aux = m_reg[0];
    cy  = 1'b0;
    case (op)
      2'd0: res = fld;
      2'd1: {cy, res} = {1'b0, fld} + {1'b0, aux};
      2'd2: res = fld & aux;
      default: res = fld ^ aux;
    endcase
    exp_wr = io_code(dst);
    base = io_code(src) ? pd : m_ivb;
    if (exp_wr) m_ivb = (base & ~rotl(mk, rot)) | (rotl(res, rot) & rotl(mk, rot));
    else begin
      if (io_code(src)) m_ivb = pd;
      if (dst != 4'd8) m_reg[slot(dst)] = res;
    end
    if (op == 2'd1) m_ovf = cy;
    else if (dst == 4'd8) m_ovf = res[0];
    @(negedge clk_i);
    check({req, " wr strobe R8"}, port_wr_o, exp_wr);
    if (exp_wr) check({req, " wr bank R3"}, port_wr_bank_o, dst[3]);
    check({req, " ivb R7"}, port_wr_data_o, m_ivb);
    instr_valid_i = 1'b0;
  endtask

  task automatic readback(input logic [3:0] code, input string req);
    exec(2'd0, code, 4'd7, 0, 7, req);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5c));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_ovf = 1'b0;
    m_ivb = '0;
    repeat (3) @(negedge clk_i);
    check("R10 wr strobe", port_wr_o, 0);
    check("R10 ivb", port_wr_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    readback(4'd3, "R10 reg3");
    readback(4'd8, "R10 ovf");

    // R3 R6: load every data register from ports
    for (int c = 0; c < 10; c++) begin
      if (c == 7 || c == 8) continue;
      left_d = 8'($urandom); right_d = 8'($urandom);
      exec(2'd0, (c % 2) ? 4'd7 : 4'd14, 4'(c), 0, 7, "R6 load");
      readback(4'(c), "R3 reg");
    end

    // R4: rotate 3, length 3 from left bank
    left_d = 8'b1011_0110;
    exec(2'd0, 4'd7, 4'd1, 3, 2, "R4 load");
    readback(4'd1, "R4 field");
    check("R4 value", port_wr_data_o, 8'b0000_0110);

    // R2 R5: add with carry then AND keeps ovf
    left_d = 8'hF0; exec(2'd0, 4'd7, 4'd0, 0, 7, "R2 aux");
    left_d = 8'h20; exec(2'd0, 4'd7, 4'd2, 0, 7, "R2 r2");
    exec(2'd1, 4'd2, 4'd3, 0, 7, "R2 add");
    readback(4'd3, "R2 sum");
    check("R2 sum value", port_wr_data_o, 8'h10);
    readback(4'd8, "R5 carry");
    check("R5 carry value", port_wr_data_o, 8'h01);
    exec(2'd2, 4'd2, 4'd4, 0, 7, "R5 and");
    readback(4'd8, "R5 ovf kept");
    check("R5 ovf kept value", port_wr_data_o, 8'h01);
    exec(2'd3, 4'd2, 4'd8, 0, 7, "R5 xor to ovf");
    readback(4'd8, "R5 ovf written");
    exec(2'd1, 4'd0, 4'd8, 0, 7, "R5 add to ovf");
    readback(4'd8, "R5 carry wins");

    // R7: merge two bits at rotate 2 into a known buffer
    left_d = 8'hAA; exec(2'd0, 4'd7, 4'd15, 0, 7, "R7 prime");
    exec(2'd0, 4'd9, 4'd7, 2, 1, "R7 merge");
    exec(2'd0, 4'd12, 4'd10, 5, 3, "R7 io to io");

    // R9: idle cycle with a write instruction on the bus
    instr_i = {2'd0, 4'd9, 4'd7, 3'd0, 3'd7};
    instr_valid_i = 1'b0;
    #1 check("R9 no rd", port_rd_o, 0);
    @(negedge clk_i);
    check("R9 no wr", port_wr_o, 0);
    check("R9 ivb held", port_wr_data_o, m_ivb);

    // R1: random instructions against the model
    for (int k = 0; k < 400; k++) begin
      left_d = 8'($urandom); right_d = 8'($urandom);
      exec(2'($urandom), 4'($urandom), 4'($urandom), int'($urandom % 8), int'($urandom % 8), "R1 rnd");
      if (k % 50 == 0)
        for (int c = 0; c < 10; c++) if (c != 7) readback(4'(c), "R1 dump");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule